// File: doc/BRIEF.md
# Static External Bus Controller

This block turns single requests from an on-chip master into read and write cycles on an asynchronous parallel bus. That bus has a 9-bit word address, a 16-bit data path, active-low output enable, write enable and address-valid strobes, and six active-low chip selects. The controller compares the 32-bit request address with six fixed windows to choose a chip select. Every chip select has its own set of static timing inputs. These set the wait states per access type, bus recovery after reads, write hold, extra latency on the first access to a page, the spacing from address-valid to output enable, the read setup and an optional extra address-hold cycle.

Only one transfer is in flight at a time. A request is accepted in a cycle where `reqValid` and `reqReady` are both high, and the clock edge that ends that cycle is the accept edge. In this brief, cycle 1 is the cycle that begins at the accept edge. The result comes back as a one-cycle `rspDone` pulse. `rspErr` marks an address that falls outside every window, and `rspRdata` carries read data. The external data bus is split into `extDataOut`, `extDataIn` and the drive enable `extDataOe`, which feeds the pad.

Top module: `xbusBridge`

## Requirements
- R1: While reset is held and after it is released, all of `extCsN`, `extOeN`, `extWeN` and `extAdvN` are high, `extDataOe` and `rspDone` are low, and `reqReady` is high.
- R2: Address windows (inclusive) select the chip select `extCsN[i]`: 0 is 0x1A800000–0x1AFFFFFF, 1 is 0x1B000000–0x1B7FFFFF, 2 is 0x1B800000–0x1BFFFFFF, 5 is 0x1C000000–0x1C7FFFFF, 4 is 0x1C800000–0x1CFFFFFF, and 3 is 0x1D000000–0x24FFFFFF. At most one chip select is low at any time. `extAddr` equals request address bits [9:1] and stays stable while the chip select is low.
- R3: A request outside all windows never asserts a chip select. It produces `rspDone` and `rspErr` together in cycle 1 and does not change the page or recovery history.
- R4: In a read with no recovery, the chip select is low from cycle 1 and `extAdvN` is low in cycle 1 only. `extOeN` first goes low in cycle 2+max(rdHold, advOe+addrHold) and stays low for rdWait+1 cycles plus any page latency.
- R5: In a write with no recovery, the chip select and `extAdvN` behave as in R4. `extWeN` goes low in cycle 2+addrHold and stays low for wrWait+1 cycles plus any page latency.
- R6: After the write strobe, the chip select stays low for wrHold+1 more cycles with `extWeN` high.
- R7: An access is to a new page if it is the first valid access since reset, if its chip select differs from the previous valid access, or if request address bits [31:4] differ from that access. A new page adds rdLat or wrLat (0–255) cycles to the strobe of that access.
- R8: If the previous valid access was a read, and the new access either uses another chip select or is a write, then max(rec,1) idle cycles come before the chip select asserts. Here rec is the previous chip select's 4-bit recovery field, and the chip select first goes low in cycle rec'+1, where rec' is that idle count. All other cases take no idle cycles.
- R9: With addrHold set, one extra cycle is placed between the address-valid cycle and the write strobe, and it is added to advOe in the read spacing of R4.
- R10: `reqReady` is low from cycle 1 until the cycle after the `rspDone` cycle. `rspDone` is high for exactly one cycle, one cycle after the strobe or write hold ends, and all chip selects are high in that cycle.
- R11: `extDataOe` is high on every cycle in which a write's chip select is low, with `extDataOut` equal to the request write data. It is never high during a read.
- R12: `rspRdata` in the `rspDone` cycle of a read equals the `extDataIn` value present in the last cycle with `extOeN` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reqValid | input | 1 | Request present |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqAddr | input | 32 | Byte address of the request |
| reqWdata | input | 16 | Write data |
| reqReady | output | 1 | Controller idle, request accepted this cycle if valid |
| rspDone | output | 1 | Transfer finished (one cycle) |
| rspErr | output | 1 | Address outside every window, valid with rspDone |
| rspRdata | output | 16 | Read data, valid with rspDone |
| cfgRecov | input | 24 | Recovery field, 4 bits per chip select |
| cfgWrHold | input | 24 | Write hold field, 4 bits per chip select |
| cfgRdWait | input | 24 | Read wait field, 4 bits per chip select |
| cfgWrWait | input | 24 | Write wait field, 4 bits per chip select |
| cfgRdHold | input | 24 | Read setup before output enable, 4 bits per chip select |
| cfgRdLat | input | 48 | Read new-page latency, 8 bits per chip select |
| cfgWrLat | input | 48 | Write new-page latency, 8 bits per chip select |
| cfgAdvOe | input | 12 | Address-valid to output-enable spacing, 2 bits per chip select |
| cfgAddrHold | input | 6 | Extra address-hold cycle enable, 1 bit per chip select |
| extAddr | output | 9 | External word address |
| extCsN | output | 6 | Active-low chip selects |
| extOeN | output | 1 | Active-low output enable |
| extWeN | output | 1 | Active-low write enable |
| extAdvN | output | 1 | Active-low address valid |
| extDataOut | output | 16 | Data driven toward the bus |
| extDataOe | output | 1 | Drive enable for extDataOut |
| extDataIn | input | 16 | Data received from the bus |

## Verification
A wrong phase counter or a wrong field selection appears in the very next access as a strobe that starts or ends one or more cycles away from the expected cycle. For this reason the bench measures where every strobe edge falls and how long each strobe lasts, for each transfer. Corrupted page or recovery history is visible only in the following access, which then gains or loses its latency or idle cycles. Sequences are therefore chained across chip selects and access types. A bad capture point appears at once in `rspRdata`, because the bench's device model returns a different value on each output-enable cycle.

// File: rtl/xbusPkg.sv
package xbusPkg;
  localparam int NUM_CS  = 6;
  localparam int CS_W    = $clog2(NUM_CS);
  localparam int ADDR_W  = 32;
  localparam int PAGE_LSB = 4;
  localparam int PAGE_W  = ADDR_W - PAGE_LSB;

  typedef enum logic [2:0] {
    ST_IDLE, ST_RECOV, ST_ADDR, ST_PRE, ST_STROBE, ST_HOLD, ST_DONE
  } xbusState_t;

  typedef struct packed {
    logic loadReq;
    logic csOn;
    logic advOn;
    logic oeOn;
    logic weOn;
    logic drvOn;
    logic capRd;
    logic done;
    logic err;
  } xbusStrobe_t;

  // inclusive window limits per chip select
  function automatic logic [ADDR_W-1:0] winLo(input int idx);
    case (idx)
      0:       return 32'h1A80_0000;
      1:       return 32'h1B00_0000;
      2:       return 32'h1B80_0000;
      3:       return 32'h1D00_0000;
      4:       return 32'h1C80_0000;
      5:       return 32'h1C00_0000;
      default: return 32'hFFFF_FFFF;
    endcase
  endfunction

  function automatic logic [ADDR_W-1:0] winHi(input int idx);
    case (idx)
      0:       return 32'h1AFF_FFFF;
      1:       return 32'h1B7F_FFFF;
      2:       return 32'h1BFF_FFFF;
      3:       return 32'h24FF_FFFF;
      4:       return 32'h1CFF_FFFF;
      5:       return 32'h1C7F_FFFF;
      default: return 32'h0000_0000;
    endcase
  endfunction
endpackage

// File: rtl/xbusData.sv
module xbusData
  import xbusPkg::*;
#(
  parameter int DATA_W = 16,
  parameter int EXT_AW = 9
) (
  input  logic                clk,
  input  logic                rst,
  input  xbusStrobe_t         stb,
  input  logic [ADDR_W-1:0]   reqAddr,
  input  logic [DATA_W-1:0]   reqWdata,
  input  logic [DATA_W-1:0]   extDataIn,
  output logic                decHit,
  output logic [CS_W-1:0]     decCs,
  output logic [PAGE_W-1:0]   decPage,
  output logic [EXT_AW-1:0]   extAddr,
  output logic [NUM_CS-1:0]   extCsN,
  output logic                extOeN,
  output logic                extWeN,
  output logic                extAdvN,
  output logic [DATA_W-1:0]   extDataOut,
  output logic                extDataOe,
  output logic                rspDone,
  output logic                rspErr,
  output logic [DATA_W-1:0]   rspRdata
);
  logic [NUM_CS-1:0] hitVec;
  logic [EXT_AW-1:0] addrReg;
  logic [DATA_W-1:0] wdataReg;
  logic [DATA_W-1:0] rdataReg;
  logic [CS_W-1:0]   csReg;

  for (genvar g = 0; g < NUM_CS; g++) begin : g_win
    assign hitVec[g] = (reqAddr >= winLo(g)) && (reqAddr <= winHi(g));
  end

  always_comb begin
    decCs = '0;
    for (int i = NUM_CS - 1; i >= 0; i--) begin
      if (hitVec[i]) decCs = CS_W'(i);
    end
  end

  assign decHit  = |hitVec;
  assign decPage = reqAddr[ADDR_W-1:PAGE_LSB];

  always_ff @(posedge clk) begin
    if (rst) begin
      addrReg  <= '0;
      wdataReg <= '0;
      rdataReg <= '0;
      csReg    <= '0;
    end else begin
      if (stb.loadReq) begin
        addrReg  <= reqAddr[EXT_AW:1];
        wdataReg <= reqWdata;
        csReg    <= decCs;
      end
      if (stb.capRd) rdataReg <= extDataIn;
    end
  end

  for (genvar g = 0; g < NUM_CS; g++) begin : g_csPin
    assign extCsN[g] = !(stb.csOn && (csReg == CS_W'(g)));
  end

  assign extAddr    = addrReg;
  assign extOeN     = !stb.oeOn;
  assign extWeN     = !stb.weOn;
  assign extAdvN    = !stb.advOn;
  assign extDataOut = wdataReg;
  assign extDataOe  = stb.drvOn;
  assign rspDone    = stb.done;
  assign rspErr     = stb.err;
  assign rspRdata   = rdataReg;
endmodule

// File: rtl/xbusCtrl.sv
module xbusCtrl
  import xbusPkg::*;
#(
  parameter int WAIT_W = 4,
  parameter int LAT_W  = 8,
  parameter int SPC_W  = 2
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      reqValid,
  input  logic                      reqWrite,
  input  logic                      decHit,
  input  logic [CS_W-1:0]           decCs,
  input  logic [PAGE_W-1:0]         decPage,
  input  logic [NUM_CS*WAIT_W-1:0]  cfgRecov,
  input  logic [NUM_CS*WAIT_W-1:0]  cfgWrHold,
  input  logic [NUM_CS*WAIT_W-1:0]  cfgRdWait,
  input  logic [NUM_CS*WAIT_W-1:0]  cfgWrWait,
  input  logic [NUM_CS*WAIT_W-1:0]  cfgRdHold,
  input  logic [NUM_CS*LAT_W-1:0]   cfgRdLat,
  input  logic [NUM_CS*LAT_W-1:0]   cfgWrLat,
  input  logic [NUM_CS*SPC_W-1:0]   cfgAdvOe,
  input  logic [NUM_CS-1:0]         cfgAddrHold,
  output logic                      reqReady,
  output xbusStrobe_t               stb
);
  localparam int TBL   = 2 ** CS_W;
  localparam int CNT_W = $clog2((1 << LAT_W) + (1 << WAIT_W) + 2);

  logic [WAIT_W-1:0] recA [TBL];
  logic [WAIT_W-1:0] whA  [TBL];
  logic [WAIT_W-1:0] rwA  [TBL];
  logic [WAIT_W-1:0] wwA  [TBL];
  logic [WAIT_W-1:0] rhA  [TBL];
  logic [LAT_W-1:0]  rlA  [TBL];
  logic [LAT_W-1:0]  wlA  [TBL];
  logic [SPC_W-1:0]  aoA  [TBL];
  logic              ahA  [TBL];

  for (genvar g = 0; g < TBL; g++) begin : g_tbl
    if (g < NUM_CS) begin : g_live
      assign recA[g] = cfgRecov[g*WAIT_W +: WAIT_W];
      assign whA[g]  = cfgWrHold[g*WAIT_W +: WAIT_W];
      assign rwA[g]  = cfgRdWait[g*WAIT_W +: WAIT_W];
      assign wwA[g]  = cfgWrWait[g*WAIT_W +: WAIT_W];
      assign rhA[g]  = cfgRdHold[g*WAIT_W +: WAIT_W];
      assign rlA[g]  = cfgRdLat[g*LAT_W +: LAT_W];
      assign wlA[g]  = cfgWrLat[g*LAT_W +: LAT_W];
      assign aoA[g]  = cfgAdvOe[g*SPC_W +: SPC_W];
      assign ahA[g]  = cfgAddrHold[g];
    end else begin : g_pad
      assign recA[g] = '0;
      assign whA[g]  = '0;
      assign rwA[g]  = '0;
      assign wwA[g]  = '0;
      assign rhA[g]  = '0;
      assign rlA[g]  = '0;
      assign wlA[g]  = '0;
      assign aoA[g]  = '0;
      assign ahA[g]  = 1'b0;
    end
  end

  xbusState_t        state;
  logic [CNT_W-1:0]  cnt;
  logic [CS_W-1:0]   curCs;
  logic              curWrite;
  logic              curNewPage;
  logic              errFlag;
  logic              lastValid;
  logic [CS_W-1:0]   lastCs;
  logic [PAGE_W-1:0] lastPage;
  logic              lastRead;

  logic             accept, newPageNow, needRec;
  logic [CNT_W-1:0] recLen, preLen, strobeLen, holdLen, spcAh;

  assign accept     = reqValid && (state == ST_IDLE);
  assign newPageNow = !lastValid || (decCs != lastCs) || (decPage != lastPage);
  assign needRec    = lastValid && lastRead && ((decCs != lastCs) || reqWrite);

  always_comb begin
    recLen = (recA[lastCs] == '0) ? CNT_W'(1) : CNT_W'(recA[lastCs]);
    spcAh  = CNT_W'(aoA[curCs]) + CNT_W'(ahA[curCs]);
    if (curWrite) preLen = CNT_W'(ahA[curCs]);
    else          preLen = (CNT_W'(rhA[curCs]) > spcAh) ? CNT_W'(rhA[curCs]) : spcAh;
    strobeLen = CNT_W'(curWrite ? wwA[curCs] : rwA[curCs]) + CNT_W'(1)
              + (curNewPage ? CNT_W'(curWrite ? wlA[curCs] : rlA[curCs]) : CNT_W'(0));
    holdLen = CNT_W'(whA[curCs]);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= ST_IDLE;
      cnt        <= '0;
      curCs      <= '0;
      curWrite   <= 1'b0;
      curNewPage <= 1'b0;
      errFlag    <= 1'b0;
      lastValid  <= 1'b0;
      lastCs     <= '0;
      lastPage   <= '0;
      lastRead   <= 1'b0;
    end else begin
      unique case (state)
        ST_IDLE: if (accept) begin
          curCs    <= decCs;
          curWrite <= reqWrite;
          if (!decHit) begin
            errFlag <= 1'b1;
            state   <= ST_DONE;
          end else begin
            errFlag    <= 1'b0;
            curNewPage <= newPageNow;
            lastValid  <= 1'b1;
            lastCs     <= decCs;
            lastPage   <= decPage;
            lastRead   <= !reqWrite;
            if (needRec) begin
              state <= ST_RECOV;
              cnt   <= recLen - CNT_W'(1);
            end else begin
              state <= ST_ADDR;
            end
          end
        end
        ST_RECOV: begin
          if (cnt == '0) state <= ST_ADDR;
          else           cnt   <= cnt - CNT_W'(1);
        end
        ST_ADDR: begin
          if (preLen == '0) begin
            state <= ST_STROBE;
            cnt   <= strobeLen - CNT_W'(1);
          end else begin
            state <= ST_PRE;
            cnt   <= preLen - CNT_W'(1);
          end
        end
        ST_PRE: begin
          if (cnt == '0) begin
            state <= ST_STROBE;
            cnt   <= strobeLen - CNT_W'(1);
          end else begin
            cnt <= cnt - CNT_W'(1);
          end
        end
        ST_STROBE: begin
          if (cnt != '0) begin
            cnt <= cnt - CNT_W'(1);
          end else if (curWrite) begin
            state <= ST_HOLD;
            cnt   <= holdLen;
          end else begin
            state <= ST_DONE;
          end
        end
        ST_HOLD: begin
          if (cnt == '0) state <= ST_DONE;
          else           cnt   <= cnt - CNT_W'(1);
        end
        ST_DONE: state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    stb         = '0;
    stb.loadReq = accept;
    stb.csOn    = (state == ST_ADDR) || (state == ST_PRE) ||
                  (state == ST_STROBE) || (state == ST_HOLD);
    stb.advOn   = (state == ST_ADDR);
    stb.oeOn    = (state == ST_STROBE) && !curWrite;
    stb.weOn    = (state == ST_STROBE) && curWrite;
    stb.drvOn   = stb.csOn && curWrite;
    stb.capRd   = stb.oeOn && (cnt == '0);
    stb.done    = (state == ST_DONE);
    stb.err     = (state == ST_DONE) && errFlag;
  end

  assign reqReady = (state == ST_IDLE);
endmodule

// File: rtl/xbusBridge.sv
module xbusBridge
  import xbusPkg::*;
#(
  parameter int DATA_W = 16,
  parameter int EXT_AW = 9,
  parameter int WAIT_W = 4,
  parameter int LAT_W  = 8,
  parameter int SPC_W  = 2
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      reqValid,
  input  logic                      reqWrite,
  input  logic [ADDR_W-1:0]         reqAddr,
  input  logic [DATA_W-1:0]         reqWdata,
  output logic                      reqReady,
  output logic                      rspDone,
  output logic                      rspErr,
  output logic [DATA_W-1:0]         rspRdata,
  input  logic [NUM_CS*WAIT_W-1:0]  cfgRecov,
  input  logic [NUM_CS*WAIT_W-1:0]  cfgWrHold,
  input  logic [NUM_CS*WAIT_W-1:0]  cfgRdWait,
  input  logic [NUM_CS*WAIT_W-1:0]  cfgWrWait,
  input  logic [NUM_CS*WAIT_W-1:0]  cfgRdHold,
  input  logic [NUM_CS*LAT_W-1:0]   cfgRdLat,
  input  logic [NUM_CS*LAT_W-1:0]   cfgWrLat,
  input  logic [NUM_CS*SPC_W-1:0]   cfgAdvOe,
  input  logic [NUM_CS-1:0]         cfgAddrHold,
  output logic [EXT_AW-1:0]         extAddr,
  output logic [NUM_CS-1:0]         extCsN,
  output logic                      extOeN,
  output logic                      extWeN,
  output logic                      extAdvN,
  output logic [DATA_W-1:0]         extDataOut,
  output logic                      extDataOe,
  input  logic [DATA_W-1:0]         extDataIn
);
  xbusStrobe_t       stb;
  logic              decHit;
  logic [CS_W-1:0]   decCs;
  logic [PAGE_W-1:0] decPage;

  xbusCtrl #(.WAIT_W(WAIT_W), .LAT_W(LAT_W), .SPC_W(SPC_W)) u_ctrl (
    .clk(clk), .rst(rst), .reqValid(reqValid), .reqWrite(reqWrite),
    .decHit(decHit), .decCs(decCs), .decPage(decPage),
    .cfgRecov(cfgRecov), .cfgWrHold(cfgWrHold), .cfgRdWait(cfgRdWait),
    .cfgWrWait(cfgWrWait), .cfgRdHold(cfgRdHold), .cfgRdLat(cfgRdLat),
    .cfgWrLat(cfgWrLat), .cfgAdvOe(cfgAdvOe), .cfgAddrHold(cfgAddrHold),
    .reqReady(reqReady), .stb(stb)
  );

  xbusData #(.DATA_W(DATA_W), .EXT_AW(EXT_AW)) u_data (
    .clk(clk), .rst(rst), .stb(stb), .reqAddr(reqAddr), .reqWdata(reqWdata),
    .extDataIn(extDataIn), .decHit(decHit), .decCs(decCs), .decPage(decPage),
    .extAddr(extAddr), .extCsN(extCsN), .extOeN(extOeN), .extWeN(extWeN),
    .extAdvN(extAdvN), .extDataOut(extDataOut), .extDataOe(extDataOe),
    .rspDone(rspDone), .rspErr(rspErr), .rspRdata(rspRdata)
  );
endmodule

// File: rtl/xbusChecker.sv
module xbusChecker
  import xbusPkg::*;
#(
  parameter int EXT_AW = 9
) (
  input logic              clk,
  input logic              rst,
  input logic [NUM_CS-1:0] extCsN,
  input logic              extOeN,
  input logic              extWeN,
  input logic              extAdvN,
  input logic              extDataOe,
  input logic [EXT_AW-1:0] extAddr,
  input logic              reqReady,
  input logic              rspDone,
  input logic              rspErr
);
  logic csAny;
  assign csAny = (extCsN != '1);

  AST_CS_ONEHOT: assert property (@(posedge clk) disable iff (rst)
    $onehot0(~extCsN)); // R2
  AST_ADDR_STABLE: assert property (@(posedge clk) disable iff (rst)
    (csAny && $past(extCsN) == extCsN) |-> $stable(extAddr)); // R2
  AST_ERR_NO_BUS: assert property (@(posedge clk) disable iff (rst)
    rspErr |-> (rspDone && !csAny)); // R3
  AST_OE_UNDER_CS: assert property (@(posedge clk) disable iff (rst)
    !extOeN |-> (csAny && extWeN)); // R4
  AST_WE_UNDER_CS: assert property (@(posedge clk) disable iff (rst)
    !extWeN |-> csAny); // R5
  AST_ADV_SINGLE: assert property (@(posedge clk) disable iff (rst)
    !extAdvN |=> extAdvN); // R9
  AST_ADV_UNDER_CS: assert property (@(posedge clk) disable iff (rst)
    !extAdvN |-> csAny); // R9
  AST_BUSY_NOT_READY: assert property (@(posedge clk) disable iff (rst)
    (csAny || rspDone) |-> !reqReady); // R10
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
    rspDone |=> !rspDone); // R10
  AST_DONE_CS_IDLE: assert property (@(posedge clk) disable iff (rst)
    rspDone |-> !csAny); // R10
  AST_NO_DRIVE_READ: assert property (@(posedge clk) disable iff (rst)
    !extOeN |-> !extDataOe); // R11
  AST_DRIVE_UNDER_CS: assert property (@(posedge clk) disable iff (rst)
    extDataOe |-> csAny); // R11
endmodule

bind xbusBridge xbusChecker #(.EXT_AW(EXT_AW)) u_chk (
  .clk(clk), .rst(rst), .extCsN(extCsN), .extOeN(extOeN), .extWeN(extWeN),
  .extAdvN(extAdvN), .extDataOe(extDataOe), .extAddr(extAddr),
  .reqReady(reqReady), .rspDone(rspDone), .rspErr(rspErr)
);

// File: tb/sim_xbusBridge.sv
`timescale 1ns/1ps
module sim_xbusBridge;
  logic clk = 1'b0;
  logic rst = 1'b1;
  always #2.5 clk = ~clk;

  logic        reqValid = 1'b0, reqWrite = 1'b0;
  logic [31:0] reqAddr = '0;
  logic [15:0] reqWdata = '0;
  logic        reqReady, rspDone, rspErr;
  logic [15:0] rspRdata;
  logic [23:0] cfgRecov, cfgWrHold, cfgRdWait, cfgWrWait, cfgRdHold;
  logic [47:0] cfgRdLat, cfgWrLat;
  logic [11:0] cfgAdvOe;
  logic [5:0]  cfgAddrHold;
  logic [8:0]  extAddr;
  logic [5:0]  extCsN;
  logic        extOeN, extWeN, extAdvN, extDataOe;
  logic [15:0] extDataOut, extDataIn;
  logic [15:0] oeCnt;

  int cRec[6], cWh[6], cRw[6], cWw[6], cRh[6], cRl[6], cWl[6], cAo[6], cAh[6];
  int nChecks = 0, nFail = 0;
  bit mLastValid = 0, mLastRead = 0;
  int mLastCs = 0;
  logic [27:0] mLastPage = '0;

  always_comb begin
    for (int i = 0; i < 6; i++) begin
      cfgRecov[i*4 +: 4]  = 4'(cRec[i]);
      cfgWrHold[i*4 +: 4] = 4'(cWh[i]);
      cfgRdWait[i*4 +: 4] = 4'(cRw[i]);
      cfgWrWait[i*4 +: 4] = 4'(cWw[i]);
      cfgRdHold[i*4 +: 4] = 4'(cRh[i]);
      cfgRdLat[i*8 +: 8]  = 8'(cRl[i]);
      cfgWrLat[i*8 +: 8]  = 8'(cWl[i]);
      cfgAdvOe[i*2 +: 2]  = 2'(cAo[i]);
      cfgAddrHold[i]      = cAh[i][0];
    end
  end

  function automatic logic [15:0] devPat(input logic [8:0] a);
    return {a[6:0], a} ^ 16'h5A3C;
  endfunction

  // device model: value changes on every output-enable cycle
  always_ff @(posedge clk) oeCnt <= extOeN ? 16'd0 : oeCnt + 16'd1;
  assign extDataIn = extOeN ? 16'hDEAD : devPat(extAddr) + oeCnt;

  xbusBridge u0 (.*);

  function automatic int expDecode(input logic [31:0] a);
    int t;
    t = int'(a >> 23);
    if (t == 'h35) return 0;
    if (t == 'h36) return 1;
    if (t == 'h37) return 2;
    if (t == 'h38) return 5;
    if (t == 'h39) return 4;
    if (t >= 'h3A && t <= 'h49) return 3;
    return -1;
  endfunction

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic runAccess(input bit wr, input logic [31:0] addr, input logic [15:0] wd);
    int cs, rec, lat, k, w, pre;
    bit np, hit;
    int firstCs, csSeen, advCnt, advAt, oeFirst, oeLen, weFirst, weLen, holdLen, doneAt;
    bit errSeen, drvBad, addrBad, readyBad, afterWe;
    logic [15:0] rd;
    cs = expDecode(addr);
    hit = (cs >= 0);
    np = !mLastValid || cs != mLastCs || addr[31:4] != mLastPage;
    rec = 0;
    if (hit && mLastValid && mLastRead && (cs != mLastCs || wr))
      rec = (cRec[mLastCs] == 0) ? 1 : cRec[mLastCs];
    firstCs = 0; csSeen = -1; advCnt = 0; advAt = 0; oeFirst = 0; oeLen = 0;
    weFirst = 0; weLen = 0; holdLen = 0; doneAt = 0; errSeen = 0;
    drvBad = 0; addrBad = 0; readyBad = 0; afterWe = 0; rd = '0;
    @(negedge clk);
    k = 0;
    while (!reqReady && k < 1000) begin @(negedge clk); k++; end
    chk(reqReady == 1'b1, "R10", "ready before request", int'(reqReady), 1);
    reqValid = 1'b1; reqWrite = wr; reqAddr = addr; reqWdata = wd;
    @(posedge clk);
    k = 0;
    while (k < 2000) begin
      @(negedge clk);
      k++;
      if (k == 1) begin reqValid = 1'b0; reqWdata = ~wd; end
      if (rspDone) begin
        doneAt = k; errSeen = rspErr; rd = rspRdata;
        chk(extCsN == 6'h3F, "R10", "chip selects high at done", int'(extCsN), 'h3F);
        break;
      end
      if (reqReady) readyBad = 1;
      if (extCsN != 6'h3F) begin
        if (firstCs == 0) begin
          firstCs = k;
          for (int i = 0; i < 6; i++) if (!extCsN[i]) csSeen = i;
        end
        if (extAddr != addr[9:1]) addrBad = 1;
        if (wr && (!extDataOe || extDataOut != wd)) drvBad = 1;
        if (wr && afterWe && extWeN) holdLen++;
      end
      if (!wr && extDataOe) drvBad = 1;
      if (!extAdvN) begin advCnt++; advAt = k; end
      if (!extOeN) begin if (oeFirst == 0) oeFirst = k; oeLen++; end
      if (!extWeN) begin if (weFirst == 0) weFirst = k; weLen++; afterWe = 1; end
    end
    chk(doneAt != 0, "R10", "response arrived", doneAt, 1);
    chk(!readyBad, "R10", "ready low while busy", int'(readyBad), 0);
    if (!hit) begin
      chk(doneAt == 1, "R3", "error response cycle", doneAt, 1);
      chk(errSeen == 1'b1, "R3", "error flag", int'(errSeen), 1);
      chk(firstCs == 0 && oeLen == 0 && weLen == 0, "R3", "no bus cycle", firstCs, 0);
      return;
    end
    chk(errSeen == 1'b0, "R3", "no error in window", int'(errSeen), 0);
    chk(csSeen == cs, "R2", "chip select index", csSeen, cs);
    chk(!addrBad, "R2", "external address", int'(addrBad), 0);
    chk(firstCs == rec + 1, "R8", "first chip select cycle", firstCs, rec + 1);
    chk(advCnt == 1 && advAt == firstCs, "R9", "address valid cycle", advAt, firstCs);
    chk(!drvBad, "R11", "data drive", int'(drvBad), 0);
    if (wr) begin
      lat = np ? cWl[cs] : 0;
      w = cWw[cs] + 1 + lat;
      chk(weFirst == firstCs + 1 + cAh[cs], "R9", "write strobe start", weFirst, firstCs + 1 + cAh[cs]);
      chk(weLen == w, "R7", "write strobe length", weLen, w);
      chk(holdLen == cWh[cs] + 1, "R6", "write hold length", holdLen, cWh[cs] + 1);
      chk(doneAt == weFirst + w + cWh[cs] + 1, "R5", "write done cycle", doneAt, weFirst + w + cWh[cs] + 1);
      chk(oeLen == 0, "R5", "no output enable in write", oeLen, 0);
    end else begin
      lat = np ? cRl[cs] : 0;
      w = cRw[cs] + 1 + lat;
      pre = (cRh[cs] > cAo[cs] + cAh[cs]) ? cRh[cs] : cAo[cs] + cAh[cs];
      chk(oeFirst == firstCs + 1 + pre, "R4", "output enable start", oeFirst, firstCs + 1 + pre);
      chk(oeLen == w, "R7", "output enable length", oeLen, w);
      chk(doneAt == oeFirst + w, "R4", "read done cycle", doneAt, oeFirst + w);
      chk(rd == devPat(addr[9:1]) + 16'(w - 1), "R12", "read data", int'(rd), int'(devPat(addr[9:1]) + 16'(w - 1)));
      chk(weLen == 0, "R4", "no write enable in read", weLen, 0);
    end
    mLastValid = 1; mLastCs = cs; mLastPage = addr[31:4]; mLastRead = !wr;
  endtask

  function automatic logic [31:0] csBase(input int i);
    case (i)
      0: return 32'h1A80_0000; 1: return 32'h1B00_0000; 2: return 32'h1B80_0000;
      3: return 32'h1D00_0000; 4: return 32'h1C80_0000; default: return 32'h1C00_0000;
    endcase
  endfunction

  task automatic randCfg();
    for (int i = 0; i < 6; i++) begin
      cRec[i] = $urandom % 16; cWh[i] = $urandom % 16; cRw[i] = $urandom % 16;
      cWw[i] = $urandom % 16; cRh[i] = $urandom % 16; cRl[i] = $urandom % 41;
      cWl[i] = $urandom % 41; cAo[i] = $urandom % 4; cAh[i] = $urandom % 2;
    end
  endtask

  initial begin
    #(5.0 * 150000);
    chk(1'b0, "R10", "watchdog expired", 0, 1);
    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
    $finish;
  end

  initial begin
    logic [31:0] a;
    int sel;
    void'($urandom(32'd20240611));
    for (int i = 0; i < 6; i++) begin
      cRec[i] = 0; cWh[i] = 0; cRw[i] = 0; cWw[i] = 0; cRh[i] = 0;
      cRl[i] = 0; cWl[i] = 0; cAo[i] = 0; cAh[i] = 0;
    end
    repeat (3) @(negedge clk);
    chk(extCsN == 6'h3F && extOeN && extWeN && extAdvN && !extDataOe && !rspDone,
        "R1", "pins idle in reset", int'(extCsN), 'h3F);
    rst = 1'b0;
    @(negedge clk);
    chk(extCsN == 6'h3F && extOeN && extWeN && extAdvN && !extDataOe && !rspDone && reqReady,
        "R1", "idle after reset", int'(reqReady), 1);
    // directed corner cases
    cRl[2] = 5; cRw[2] = 2; cRh[2] = 1; cAo[2] = 2; cAh[2] = 1; cRec[2] = 0;
    cWw[2] = 3; cWl[2] = 7; cWh[2] = 4; cRec[0] = 6;
    runAccess(0, 32'h1B80_0010, 16'h0);   // R7 first access after reset is new page
    runAccess(0, 32'h1B80_0012, 16'h0);   // R7 same page, no latency
    runAccess(1, 32'h1B80_0014, 16'hA5C3); // R8 read then write same CS, rec 0 gives 1
    runAccess(1, 32'h1B80_0040, 16'h1234); // R7 new page, write after write no recovery
    runAccess(0, 32'h0000_0000, 16'h0);   // R3 outside
    runAccess(0, 32'h1AFF_FFFE, 16'h0);   // R2 top of window 0
    runAccess(0, 32'h1A7F_FFFE, 16'h0);   // R3 just below window 0
    runAccess(0, 32'h24FF_FFFE, 16'h0);   // R8 recovery from CS0 field
    runAccess(0, 32'h2500_0000, 16'h0);   // R3 just above window 3
    runAccess(1, 32'h1C00_0000, 16'hFFFF); // R8 read on other CS precedes
    cRl[4] = 255;
    runAccess(0, 32'h1C80_0100, 16'h0);   // R7 maximum latency
    for (int n = 0; n < 300; n++) begin
      if (n % 20 == 0) randCfg();
      sel = $urandom % 8;
      if (sel >= 6) begin
        case ($urandom % 3)
          0: a = 32'h1A7F_FFF0 + 32'(($urandom % 8) * 2);
          1: a = 32'h2500_0000 + 32'(($urandom % 8) * 2);
          default: a = 32'h4000_0000;
        endcase
      end else if ($urandom % 3 == 0) begin
        a = csBase(sel) + ((32'($urandom) % ((sel == 3) ? 32'h0800_0000 : 32'h0080_0000)) & ~32'h1);
      end else begin
        a = csBase(sel) + 32'(($urandom % 32) * 2);
      end
      runAccess(1'($urandom % 2), a, 16'($urandom));
    end
    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
    $finish;
  end
endmodule